// File: doc/BRIEF.md
# Flash Command Engine

This block runs one short serial flash command, such as a status read, an identification read, a write enable or a sector erase, from a single 32-bit control word. The word chooses which phases the command carries and how long each one is. Software loads the command address and up to eight bytes of outgoing data beforehand, then writes the control word with its execute bit set. While the command runs the block holds a busy flag. When it finishes, up to eight received bytes can be read from two 32-bit result words.

The block does not make the serial clock itself. While chip select is low it waits for `bit_tick` pulses from a shared timing generator, and each pulse marks one serial bit period. `mosi` holds the current outgoing bit ahead of the pulse. `miso` is sampled on the clock edge that sees the pulse. All transfers use one data lane.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `busy` is 0, `cs_n` is 1, `mosi` is 0 and both result words are zero. `mosi` stays 0 whenever the block is idle.
- R2: When `ctl_wr` is high with `ctl_word[0]` set while idle, a command starts. One clock later `busy` is 1 and `cs_n` is 0. The control fields, `cmd_addr`, `wdata_lo` and `wdata_hi` are captured at that edge.
- R3: The first eight bit periods carry the opcode from `ctl_word[31:24]`, most significant bit first.
- R4: If `ctl_word[19]` is set, the opcode is followed by N address bytes, where N is `ctl_word[17:16]`+1. They are the low N bytes of `cmd_addr`, sent from the most significant of those bytes down, each byte MSB first.
- R5: `ctl_word[11:7]` gives a count of dummy bit periods, 0 to 31. They follow the address phase, or the opcode when there is no address, and `mosi` is 0 during each of them.
- R6: If `ctl_word[15]` is set, M data bytes are sent after the dummy periods, where M is `ctl_word[14:12]`+1. Byte k is bits 8k+7:8k of {`wdata_hi`,`wdata_lo`}, so bytes 0 to 3 come from `wdata_lo` with byte 0 in bits 7:0. Each byte goes out MSB first.
- R7: If `ctl_word[23]` is set and `ctl_word[15]` is not, M bytes are received, where M is `ctl_word[22:20]`+1. `mosi` is 0 during this phase. Each byte is assembled MSB first, and byte k lands in bits 8k+7:8k of {`rd_hi`,`rd_lo`}. Both result words are cleared at each start, so bytes that are not received read as zero.
- R8: `busy` stays 1 and `cs_n` stays 0 until the edge that takes the final bit pulse of the command. At that edge both return to idle. The command uses exactly the number of bit periods its phases add up to.
- R9: A `ctl_wr` with the execute bit set while `busy` is 1 is ignored. The running command continues unchanged and no new command follows it.
- R10: If both the write and read enables are set, only the write phase runs and the result words stay zero.
- R11: A `ctl_wr` whose `ctl_word[0]` is 0 starts nothing and leaves the result words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 32 | Control word: opcode, phase enables, lengths, dummy count, execute |
| cmd_addr | input | 32 | Command address, low bytes used |
| wdata_lo | input | 32 | Outgoing data bytes 0 to 3 |
| wdata_hi | input | 32 | Outgoing data bytes 4 to 7 |
| bit_tick | input | 1 | One pulse per serial bit period from the timing generator |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Chip select, active low; low also requests bit pulses |
| mosi | output | 1 | Serial data to the flash |
| rd_lo | output | 32 | Received bytes 0 to 3 |
| rd_hi | output | 32 | Received bytes 4 to 7 |

## Verification
The bench targets the phase-skipping corners: opcode-only commands, address widths of one and four bytes with unused high address bits set, and a zero dummy count. A design that got these wrong would send extra or missing bit periods, or would send the wrong address byte first. Read lengths of one, two and eight bytes are run back to back, so a design that failed to clear the result words would leave stale upper bytes behind. A command with both data enables set would, in a faulty design, add read periods after the write. An execute request made in mid-command would, in a faulty design, either restart the command with a different opcode or queue a second command.

// File: rtl/fce_pkg.sv
package fce_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 8;
    localparam int DATA_W     = MAX_BYTES * BYTE_W;
    localparam int BYTE_IDX_W = $clog2(MAX_BYTES);
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int ADR_BYTES  = WORD_W / BYTE_W;
    localparam int ADR_IDX_W  = $clog2(ADR_BYTES);
    localparam int DMY_W      = 5;

    // control word field positions
    localparam int OPC_LSB    = 24;
    localparam int RD_EN_BIT  = 23;
    localparam int RD_CNT_LSB = 20;
    localparam int AD_EN_BIT  = 19;
    localparam int AD_CNT_LSB = 16;
    localparam int WR_EN_BIT  = 15;
    localparam int WR_CNT_LSB = 12;
    localparam int DMY_LSB    = 7;
    localparam int EXEC_BIT   = 0;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADR, PH_DMY, PH_WR, PH_RD
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0]     opcode;
        logic                  rd_en;
        logic [BYTE_IDX_W-1:0] rd_last;
        logic                  ad_en;
        logic [ADR_IDX_W-1:0]  ad_last;
        logic                  wr_en;
        logic [BYTE_IDX_W-1:0] wr_last;
        logic [DMY_W-1:0]      dummy;
    } cmd_cfg_t;

    function automatic cmd_cfg_t decode_ctl(input logic [WORD_W-1:0] w);
        cmd_cfg_t c;
        c.opcode  = w[OPC_LSB +: BYTE_W];
        c.rd_en   = w[RD_EN_BIT];
        c.rd_last = w[RD_CNT_LSB +: BYTE_IDX_W];
        c.ad_en   = w[AD_EN_BIT];
        c.ad_last = w[AD_CNT_LSB +: ADR_IDX_W];
        c.wr_en   = w[WR_EN_BIT];
        c.wr_last = w[WR_CNT_LSB +: BYTE_IDX_W];
        c.dummy   = w[DMY_LSB +: DMY_W];
        return c;
    endfunction
endpackage

// File: rtl/fce_sequencer.sv
module fce_sequencer
    import fce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  tick,
    input  cmd_cfg_t              cfg,
    output phase_e                phase,
    output logic [BYTE_IDX_W-1:0] byte_idx,
    output logic [BIT_IDX_W-1:0]  bit_pos,
    output logic                  cs_n
);
    typedef struct packed {
        phase_e                phase;
        logic [BYTE_IDX_W-1:0] byte_idx;
        logic [BIT_IDX_W-1:0]  bit_pos;
        logic [DMY_W-1:0]      dcnt;
        logic                  cs_n;
    } seq_t;

    seq_t q, d;
    phase_e after_dmy, after_adr, after_opc, nxt;
    logic [BYTE_IDX_W-1:0] last_byte;
    logic phase_end;

    always_comb begin
        after_dmy = cfg.wr_en ? PH_WR : (cfg.rd_en ? PH_RD : PH_IDLE);
        after_adr = (cfg.dummy != '0) ? PH_DMY : after_dmy;
        after_opc = cfg.ad_en ? PH_ADR : after_adr;
        case (q.phase)
            PH_OPC:  begin nxt = after_opc; last_byte = '0; end
            PH_ADR:  begin nxt = after_adr; last_byte = BYTE_IDX_W'(cfg.ad_last); end
            PH_DMY:  begin nxt = after_dmy; last_byte = '0; end
            PH_WR:   begin nxt = PH_IDLE;   last_byte = cfg.wr_last; end
            PH_RD:   begin nxt = PH_IDLE;   last_byte = cfg.rd_last; end
            default: begin nxt = PH_IDLE;   last_byte = '0; end
        endcase
        if (q.phase == PH_DMY)
            phase_end = (q.dcnt == cfg.dummy - 1'b1);
        else
            phase_end = (q.bit_pos == '0) && (q.byte_idx == last_byte);

        d = q;
        if (start) begin
            d.phase    = PH_OPC;
            d.byte_idx = '0;
            d.bit_pos  = '1;
            d.dcnt     = '0;
            d.cs_n     = 1'b0;
        end else if (tick && q.phase != PH_IDLE) begin
            if (phase_end) begin
                d.phase    = nxt;
                d.byte_idx = '0;
                d.bit_pos  = '1;
                d.dcnt     = '0;
                d.cs_n     = (nxt == PH_IDLE);
            end else if (q.phase == PH_DMY) begin
                d.dcnt = q.dcnt + 1'b1;
            end else if (q.bit_pos == '0) begin
                d.bit_pos  = '1;
                d.byte_idx = q.byte_idx + 1'b1;
            end else begin
                d.bit_pos = q.bit_pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= PH_IDLE;
            q.byte_idx <= '0;
            q.bit_pos  <= '0;
            q.dcnt     <= '0;
            q.cs_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign phase    = q.phase;
    assign byte_idx = q.byte_idx;
    assign bit_pos  = q.bit_pos;
    assign cs_n     = q.cs_n;
endmodule

// File: rtl/fce_tx_select.sv
module fce_tx_select
    import fce_pkg::*;
(
    input  phase_e                phase,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic [BIT_IDX_W-1:0]  bit_pos,
    input  logic [BYTE_W-1:0]     opcode,
    input  logic [ADR_IDX_W-1:0]  ad_last,
    input  logic [WORD_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  mosi
);
    logic [ADR_IDX_W-1:0] abyte;

    always_comb begin
        // address goes out from its highest used byte downwards
        abyte = ad_last - byte_idx[ADR_IDX_W-1:0];
        case (phase)
            PH_OPC:  mosi = opcode[bit_pos];
            PH_ADR:  mosi = addr[{abyte, bit_pos}];
            PH_WR:   mosi = wdata[{byte_idx, bit_pos}];
            default: mosi = 1'b0;
        endcase
    end
endmodule

// File: rtl/fce_rx_capture.sv
module fce_rx_capture
    import fce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  cap,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic [BIT_IDX_W-1:0]  bit_pos,
    input  logic                  miso,
    output logic [DATA_W-1:0]     rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (clear)
            rdata_d = '0;
        else if (cap)
            rdata_d[{byte_idx, bit_pos}] = miso;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import fce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_word,
    input  logic [31:0] cmd_addr,
    input  logic [31:0] wdata_lo,
    input  logic [31:0] wdata_hi,
    input  logic        bit_tick,
    input  logic        miso,
    output logic        busy,
    output logic        cs_n,
    output logic        mosi,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi
);
    typedef struct packed {
        cmd_cfg_t          cfg;
        logic [WORD_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    cmd_t q, d;
    phase_e phase;
    logic [BYTE_IDX_W-1:0] byte_idx;
    logic [BIT_IDX_W-1:0]  bit_pos;
    logic [DATA_W-1:0]     rdata;
    logic start;

    assign start = ctl_wr && ctl_word[EXEC_BIT] && (phase == PH_IDLE);

    always_comb begin
        d = q;
        if (start) begin
            d.cfg   = decode_ctl(ctl_word);
            d.addr  = cmd_addr;
            d.wdata = {wdata_hi, wdata_lo};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    fce_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (bit_tick),
        .cfg      (q.cfg),
        .phase    (phase),
        .byte_idx (byte_idx),
        .bit_pos  (bit_pos),
        .cs_n     (cs_n)
    );

    fce_tx_select u_tx (
        .phase    (phase),
        .byte_idx (byte_idx),
        .bit_pos  (bit_pos),
        .opcode   (q.cfg.opcode),
        .ad_last  (q.cfg.ad_last),
        .addr     (q.addr),
        .wdata    (q.wdata),
        .mosi     (mosi)
    );

    fce_rx_capture u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .cap      (bit_tick && phase == PH_RD),
        .byte_idx (byte_idx),
        .bit_pos  (bit_pos),
        .miso     (miso),
        .rdata    (rdata)
    );

    assign busy  = (phase != PH_IDLE);
    assign rd_lo = rdata[WORD_W-1:0];
    assign rd_hi = rdata[DATA_W-1:WORD_W];
endmodule

// File: rtl/fce_checker.sv
module fce_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic [31:0] ctl_word,
    input logic        bit_tick,
    input logic        busy,
    input logic        cs_n,
    input logic        mosi,
    input logic [31:0] rd_lo,
    input logic [31:0] rd_hi
);
    assert_idle_mosi_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    assert_start_needs_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_wr && ctl_word[0]));

    assert_exec_idle_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_word[0] && !busy) |=> busy);

    assert_rx_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(rd_lo) && $stable(rd_hi)));

    assert_cs_tracks_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n == !busy);

    assert_no_end_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> busy);

    assert_exec_while_busy_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr && !bit_tick) |=> ($stable(rd_lo) && busy));
endmodule

bind flash_cmd_engine fce_checker u_fce_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_word (ctl_word),
    .bit_tick (bit_tick),
    .busy     (busy),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_word = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] wdata_lo = '0;
    logic [31:0] wdata_hi = '0;
    logic        bit_tick = 1'b0;
    logic        miso = 1'b0;
    logic        busy, cs_n, mosi;
    logic [31:0] rd_lo, rd_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit    exp_q[$];
    bit    miso_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    flash_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .cmd_addr(cmd_addr), .wdata_lo(wdata_lo), .wdata_hi(wdata_hi),
        .bit_tick(bit_tick), .miso(miso), .busy(busy), .cs_n(cs_n),
        .mosi(mosi), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] op, input logic rd_en, input int rd_n,
                                       input logic ad_en, input int ad_n, input logic wr_en,
                                       input int wr_n, input int dmy);
        logic [31:0] w = '0;
        w[31:24] = op;
        w[23]    = rd_en;
        w[22:20] = 3'(rd_n - 1);
        w[19]    = ad_en;
        w[17:16] = 2'(ad_n - 1);
        w[15]    = wr_en;
        w[14:12] = 3'(wr_n - 1);
        w[11:7]  = 5'(dmy);
        w[0]     = 1'b1;
        return w;
    endfunction

    task automatic push_bit(input bit m, input bit s, input string tag);
        exp_q.push_back(m);
        miso_q.push_back(s);
        tag_q.push_back(tag);
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) push_bit(b[i], 1'b0, tag);
    endtask

    // monitor and bit-period generator: one pulse every 4 clocks while cs_n is low
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || cs_n) begin
                div = 0;
                bit_tick = 1'b0;
            end else if (div == 3) begin
                div = 0;
                bit_tick = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "extra bit period", 64'(mosi), 64'd0);
                    miso = 1'b0;
                end else begin
                    bit e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    miso = miso_q.pop_front();
                    check(mosi === e, t, "mosi bit", 64'(mosi), 64'(e));
                end
            end else begin
                div++;
                bit_tick = 1'b0;
            end
        end
    end

    task automatic run_cmd(input logic [31:0] ctl, input logic [31:0] addr,
                           input logic [31:0] lo, input logic [31:0] hi,
                           input logic [63:0] rx, input string rtag, input bit inject);
        logic [63:0] wd;
        logic [63:0] er;
        int n;
        wd = {hi, lo};
        er = '0;
        push_byte(ctl[31:24], "R3");
        if (ctl[19]) begin
            n = int'(ctl[17:16]) + 1;
            for (int i = n - 1; i >= 0; i--) push_byte(addr[8*i +: 8], "R4");
        end
        for (int i = 0; i < int'(ctl[11:7]); i++) push_bit(1'b0, 1'b0, "R5");
        if (ctl[15]) begin
            n = int'(ctl[14:12]) + 1;
            for (int k = 0; k < n; k++) push_byte(wd[8*k +: 8], "R6");
        end else if (ctl[23]) begin
            n = int'(ctl[22:20]) + 1;
            for (int k = 0; k < n; k++) begin
                er[8*k +: 8] = rx[8*k +: 8];
                for (int i = 7; i >= 0; i--) push_bit(1'b0, rx[8*k + i], "R7");
            end
        end
        @(negedge clk);
        ctl_word = ctl; cmd_addr = addr; wdata_lo = lo; wdata_hi = hi; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        check(busy === 1'b1 && cs_n === 1'b0, "R2", "busy/cs_n after execute",
              64'({busy, cs_n}), 64'b10);
        // inputs changed after the start must not matter
        cmd_addr = ~addr; wdata_lo = ~lo; wdata_hi = ~hi;
        if (inject) begin
            repeat (5) @(negedge clk);
            ctl_word = mk(8'hFF, 1'b0, 1, 1'b1, 4, 1'b0, 1, 3);
            ctl_wr = 1'b1;
            @(negedge clk);
            ctl_wr = 1'b0;
        end
        while (busy === 1'b1) @(negedge clk);
        check(exp_q.size() == 0, "R8", "bit periods left at end", 64'(exp_q.size()), 64'd0);
        check(cs_n === 1'b1, "R8", "cs_n released", 64'(cs_n), 64'd1);
        check({rd_hi, rd_lo} === er, rtag, "result words", {rd_hi, rd_lo}, er);
        if (inject) begin
            repeat (12) @(negedge clk);
            check(busy === 1'b0 && cs_n === 1'b1, "R9", "no command after ignored execute",
                  64'({busy, cs_n}), 64'b01);
            check({rd_hi, rd_lo} === er, "R9", "results kept", {rd_hi, rd_lo}, er);
        end
        exp_q.delete(); miso_q.delete(); tag_q.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
            finish_run();
        end
    end

    initial begin
        logic [63:0] keep;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && cs_n === 1'b1 && mosi === 1'b0, "R1", "idle outputs in reset",
              64'({busy, cs_n, mosi}), 64'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({rd_hi, rd_lo} === 64'd0, "R1", "result words after reset", {rd_hi, rd_lo}, 64'd0);
        check(mosi === 1'b0, "R1", "mosi idle", 64'(mosi), 64'd0);

        // opcode only
        run_cmd(mk(8'h06, 0, 1, 0, 1, 0, 1, 0), 32'h0, 32'h0, 32'h0, 64'h0, "R3", 1'b0);
        // one-byte status read
        run_cmd(mk(8'h05, 1, 1, 0, 1, 0, 1, 0), 32'h0, 32'h0, 32'h0,
                64'h00000000_000000A5, "R7", 1'b0);
        // eight-byte read with 3 address bytes and 8 dummy periods
        run_cmd(mk(8'h0B, 1, 8, 1, 3, 0, 1, 8), 32'hEE123456, 32'h0, 32'h0,
                64'h88776655_44332211, "R7", 1'b0);
        // two-byte read: upper bytes must have been cleared (R7)
        run_cmd(mk(8'h9F, 1, 2, 0, 1, 0, 1, 0), 32'h0, 32'h0, 32'h0,
                64'hFFFFFFFF_FFFFBEEF, "R7", 1'b0);
        // erase with four and with one address byte (R4)
        run_cmd(mk(8'hD8, 0, 1, 1, 4, 0, 1, 0), 32'hA1B2C3D4, 32'h0, 32'h0, 64'h0, "R4", 1'b0);
        run_cmd(mk(8'h20, 0, 1, 1, 1, 0, 1, 0), 32'hFFFFFF5A, 32'h0, 32'h0, 64'h0, "R4", 1'b0);
        // five-byte write, then eight-byte write with address and dummy periods (R6, R5)
        run_cmd(mk(8'h01, 0, 1, 0, 1, 1, 5, 0), 32'h0, 32'h44332211, 32'h99887766,
                64'h0, "R6", 1'b0);
        run_cmd(mk(8'h02, 0, 1, 1, 2, 1, 8, 3), 32'h0000C001, 32'hDEADBEEF, 32'h0BADF00D,
                64'h0, "R6", 1'b0);
        // both data enables set: write only (R10)
        run_cmd(mk(8'h31, 1, 4, 0, 1, 1, 2, 0), 32'h0, 32'h0000A55A, 32'h0,
                64'h12345678_9ABCDEF0, "R10", 1'b0);
        // execute while busy is ignored (R9)
        run_cmd(mk(8'h4B, 1, 3, 1, 3, 0, 1, 4), 32'h00ABCDEF, 32'h0, 32'h0,
                64'h00000000_00C3B2A1, "R7", 1'b1);

        // control write without the execute bit (R11)
        keep = {rd_hi, rd_lo};
        @(negedge clk);
        ctl_word = mk(8'h05, 1, 4, 0, 1, 0, 1, 0) & ~32'h1;
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && cs_n === 1'b1, "R11", "no start without execute",
              64'({busy, cs_n}), 64'b01);
        check({rd_hi, rd_lo} === keep, "R11", "results unchanged", {rd_hi, rd_lo}, keep);

        done = 1'b1;
        finish_run();
    end
endmodule